// File: doc/BRIEF.md
# Cross-Bank Auto-Precharge Spacing Checker

This block watches a DDR2-style command stream, one command per clock, and checks the spacing between commands. Each command carries a bank number and an auto-precharge flag. After a READ or WRITE with auto precharge to one bank, commands to other banks may proceed while that bank precharges in the background. The gap they need depends on the kind of the earlier access and the kind of the later command. For each command the checker raises a violation pulse with a reason code in the same cycle. It also drives three ready signals: one says a read may go to another bank now, one says the same for a write, and one says every bank is idle.

The timing settings are CAS latency, burst length, write-to-read delay, write recovery and row precharge time, all counted in clocks. They are captured while reset is held, and all gaps are derived from them once. Two gap counters, one for reads and one for writes, are reloaded by each auto-precharge access. Each bank has its own state machine with the states BK_IDLE, BK_OPEN, BK_ACCESS and BK_CLOSING. The transitions are:
- *activate*: BK_IDLE to BK_OPEN.
- *close*: BK_OPEN to BK_CLOSING, on an explicit PRECHARGE.
- *auto-close*: BK_OPEN to BK_ACCESS, on a READ or WRITE with auto precharge.
- *access-done*: BK_ACCESS to BK_CLOSING, when the access period expires.
- *ready*: BK_CLOSING to BK_IDLE, when the precharge count expires.

The bank states decide whether a REFRESH or mode-load command is legal.

Top module: `ddr2_ap_gap_checker`

## Requirements
- R1: After reset, with `cmd` at NOP, `viol` is 0, `viol_code` is 0, and `rd_rdy`, `wr_rdy` and `idle_rdy` are all 1.
- R2: Command codes on `cmd` are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, LOAD MODE=6; `ap` marks auto precharge. Take a READ with `ap` to bank n at cycle t. A READ to a bank other than n at cycle t+k, with k below BL/2, raises `viol` with code 1.
- R3: After a READ with `ap` to bank n at cycle t, a WRITE to another bank at t+k, with k below BL/2+2, raises code 2.
- R4: After a WRITE with `ap` to bank n at cycle t, a READ to another bank at t+k, with k below (CL-1)+BL/2+W, raises code 3. W is the effective write-to-read delay.
- R5: After a WRITE with `ap` to bank n at cycle t, a WRITE to another bank at t+k, with k below BL/2, raises code 4.
- R6: The spacing rules never flag an ACTIVE or a PRECHARGE. They also never flag a READ or WRITE addressed to the same bank as the auto-precharge access that started the count.
- R7: The effective write-to-read delay W is the larger of 2 and the `cfg_wtr` value.
- R8: A REFRESH or LOAD MODE issued while any bank is not idle raises code 5. Issued when every bank is idle, it raises nothing.
- R9: Bank idle timing:
  - A PRECHARGE at cycle p to an open bank makes that bank idle from cycle p+tRP.
  - A READ with `ap` at cycle c to an open bank makes it idle from c+BL/2+tRP.
  - A WRITE with `ap` at cycle c to an open bank makes it idle from c+(CL-1)+BL/2+tWR+tRP.
  - An ACTIVE opens an idle bank.
- R10: `rd_rdy` and `wr_rdy` are 1 exactly when a READ or WRITE, respectively, to another bank would not be flagged in that cycle. `idle_rdy` is 1 exactly when every bank is idle.
- R11: The configuration inputs are sampled only while `rst_n` is low. Changing them after reset has no effect on any gap or bank timing.
- R12: Each new READ or WRITE with `ap` restarts both gap counts, with itself as the source, whatever remained of earlier counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| cmd | input | 3 | Command code for this cycle |
| bank | input | 2 | Target bank of the command |
| ap | input | 1 | Auto-precharge flag for READ and WRITE |
| cfg_cl | input | 3 | CAS latency in clocks (3 to 6) |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_wtr | input | 4 | Write-to-read delay in clocks, already rounded up |
| cfg_twr | input | 4 | Write recovery in clocks |
| cfg_trp | input | 4 | Row precharge time in clocks (at least 2) |
| viol | output | 1 | The command in this cycle breaks a rule |
| viol_code | output | 3 | Reason: 0 none, 1..4 spacing rules, 5 bank not idle |
| rd_rdy | output | 1 | A READ to another bank is allowed now |
| wr_rdy | output | 1 | A WRITE to another bank is allowed now |
| idle_rdy | output | 1 | All banks are idle |

## Verification
The bench builds the block with its default of four banks and resets it twice with different settings. The first setting is burst length 8, CL 5, write-to-read 3, tWR 4 and tRP 3. It makes the long write-to-read gap of 11 clocks reachable. The second setting is burst length 4, CL 3, write-to-read 1, tWR 2 and tRP 2. It drives the write-to-read clamp to 2 and the shortest legal precharge window. Every rule is swept cycle by cycle across its boundary, and idle timing is probed with a REFRESH issued every cycle until the bank settles.

// File: rtl/ap_gap_pkg.sv
package ap_gap_pkg;

    localparam int GAP_W = 6;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_MODE = 3'd6,
        CMD_RSV  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPEN,
        BK_ACCESS,
        BK_CLOSING
    } bank_st_e;

    typedef enum logic [2:0] {
        VC_NONE     = 3'd0,
        VC_RDA_RD   = 3'd1,
        VC_RDA_WR   = 3'd2,
        VC_WRA_RD   = 3'd3,
        VC_WRA_WR   = 3'd4,
        VC_NOT_IDLE = 3'd5
    } viol_e;

    typedef struct packed {
        logic [GAP_W-1:0] gap_rr;   // read-ap source, read follower
        logic [GAP_W-1:0] gap_rw;   // read-ap source, write follower
        logic [GAP_W-1:0] gap_wr;   // write-ap source, read follower
        logic [GAP_W-1:0] gap_ww;   // write-ap source, write follower
        logic [GAP_W-1:0] acc_rd;   // access period of a read with ap
        logic [GAP_W-1:0] acc_wr;   // access period of a write with ap
        logic [GAP_W-1:0] trp;      // precharge period
    } gap_cfg_t;

endpackage

// File: rtl/ap_thr_calc.sv
module ap_thr_calc
    import ap_gap_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_cl,
    input  logic             cfg_bl8,
    input  logic [CFG_W-1:0] cfg_wtr,
    input  logic [CFG_W-1:0] cfg_twr,
    input  logic [CFG_W-1:0] cfg_trp,
    output gap_cfg_t         thr
);

    localparam logic [GAP_W-1:0] MIN_WTR = GAP_W'(2);

    gap_cfg_t         thr_nxt;
    logic [GAP_W-1:0] half_bl;
    logic [GAP_W-1:0] wtr_eff;
    logic [GAP_W-1:0] cl_m1;

    always_comb begin
        half_bl = cfg_bl8 ? GAP_W'(4) : GAP_W'(2);
        wtr_eff = (GAP_W'(cfg_wtr) < MIN_WTR) ? MIN_WTR : GAP_W'(cfg_wtr);
        cl_m1   = GAP_W'(cfg_cl) - GAP_W'(1);
        thr_nxt.gap_rr = half_bl;
        thr_nxt.gap_rw = half_bl + GAP_W'(2);
        thr_nxt.gap_wr = cl_m1 + half_bl + wtr_eff;
        thr_nxt.gap_ww = half_bl;
        thr_nxt.acc_rd = half_bl;
        thr_nxt.acc_wr = cl_m1 + half_bl + GAP_W'(cfg_twr);
        thr_nxt.trp    = GAP_W'(cfg_trp);
    end

    // Captured only while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= thr_nxt;
        end
    end

endmodule

// File: rtl/ap_gap_timer.sv
module ap_gap_timer
    import ap_gap_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic              ap,
    input  gap_cfg_t          thr,
    output viol_e             gap_code,
    output logic              rd_rdy,
    output logic              wr_rdy
);

    logic [GAP_W-1:0]  rd_cnt;
    logic [GAP_W-1:0]  wr_cnt;
    logic [BANK_W-1:0] src_bank;
    logic              src_wr;
    logic              ap_access;
    logic              other_bank;

    assign ap_access  = ap && (cmd == CMD_RD || cmd == CMD_WR);
    assign other_bank = (bank != src_bank);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt   <= '0;
            wr_cnt   <= '0;
            src_bank <= '0;
            src_wr   <= 1'b0;
        end else if (ap_access) begin
            src_bank <= bank;
            src_wr   <= (cmd == CMD_WR);
            rd_cnt   <= ((cmd == CMD_WR) ? thr.gap_wr : thr.gap_rr) - GAP_W'(1);
            wr_cnt   <= ((cmd == CMD_WR) ? thr.gap_ww : thr.gap_rw) - GAP_W'(1);
        end else begin
            if (rd_cnt != '0) rd_cnt <= rd_cnt - GAP_W'(1);
            if (wr_cnt != '0) wr_cnt <= wr_cnt - GAP_W'(1);
        end
    end

    always_comb begin
        gap_code = VC_NONE;
        if (cmd == CMD_RD && other_bank && rd_cnt != '0) begin
            gap_code = src_wr ? VC_WRA_RD : VC_RDA_RD;
        end else if (cmd == CMD_WR && other_bank && wr_cnt != '0) begin
            gap_code = src_wr ? VC_WRA_WR : VC_RDA_WR;
        end
    end

    assign rd_rdy = (rd_cnt == '0);
    assign wr_rdy = (wr_cnt == '0);

endmodule

// File: rtl/ap_bank_fsm.sv
module ap_bank_fsm
    import ap_gap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel,
    input  cmd_e     cmd,
    input  logic     ap,
    input  gap_cfg_t thr,
    output logic     idle
);

    bank_st_e         st, st_nxt;
    logic [GAP_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            BK_IDLE: begin
                if (sel && cmd == CMD_ACT) st_nxt = BK_OPEN;       // activate
            end
            BK_OPEN: begin
                if (sel && cmd == CMD_PRE) begin                   // close
                    st_nxt  = BK_CLOSING;
                    cnt_nxt = thr.trp - GAP_W'(1);
                end else if (sel && ap && (cmd == CMD_RD || cmd == CMD_WR)) begin
                    st_nxt  = BK_ACCESS;                           // auto-close
                    cnt_nxt = ((cmd == CMD_WR) ? thr.acc_wr : thr.acc_rd) - GAP_W'(1);
                end
            end
            BK_ACCESS: begin
                if (cnt == '0) begin                               // access-done
                    st_nxt  = BK_CLOSING;
                    cnt_nxt = thr.trp - GAP_W'(1);
                end else begin
                    cnt_nxt = cnt - GAP_W'(1);
                end
            end
            BK_CLOSING: begin
                if (cnt <= GAP_W'(1)) begin                        // ready
                    st_nxt  = BK_IDLE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt - GAP_W'(1);
                end
            end
            default: st_nxt = BK_IDLE;
        endcase
    end

    always_comb begin
        idle = (st == BK_IDLE);
    end

endmodule

// File: rtl/ddr2_ap_gap_checker.sv
module ddr2_ap_gap_checker
    import ap_gap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CFG_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic              ap,
    input  logic [2:0]        cfg_cl,
    input  logic              cfg_bl8,
    input  logic [CFG_W-1:0]  cfg_wtr,
    input  logic [CFG_W-1:0]  cfg_twr,
    input  logic [CFG_W-1:0]  cfg_trp,
    output logic              viol,
    output logic [2:0]        viol_code,
    output logic              rd_rdy,
    output logic              wr_rdy,
    output logic              idle_rdy
);

    cmd_e                 cmd_t;
    gap_cfg_t             thr;
    viol_e                gap_code;
    viol_e                code_out;
    logic [NUM_BANKS-1:0] bank_idle;

    assign cmd_t = cmd_e'(cmd);

    ap_thr_calc #(.CFG_W(CFG_W)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_cl  (cfg_cl),
        .cfg_bl8 (cfg_bl8),
        .cfg_wtr (cfg_wtr),
        .cfg_twr (cfg_twr),
        .cfg_trp (cfg_trp),
        .thr     (thr)
    );

    ap_gap_timer #(.BANK_W(BANK_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd_t),
        .bank     (bank),
        .ap       (ap),
        .thr      (thr),
        .gap_code (gap_code),
        .rd_rdy   (rd_rdy),
        .wr_rdy   (wr_rdy)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ap_bank_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (bank == BANK_W'(b)),
            .cmd   (cmd_t),
            .ap    (ap),
            .thr   (thr),
            .idle  (bank_idle[b])
        );
    end

    assign idle_rdy = &bank_idle;

    always_comb begin
        code_out = gap_code;
        if (gap_code == VC_NONE && (cmd_t == CMD_REF || cmd_t == CMD_MODE) && !idle_rdy) begin
            code_out = VC_NOT_IDLE;
        end
    end

    assign viol_code = code_out;
    assign viol      = (code_out != VC_NONE);

endmodule

// File: rtl/ddr2_ap_gap_props.sv
module ddr2_ap_gap_props (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd,
    input logic       ap,
    input logic       viol,
    input logic [2:0] viol_code,
    input logic       rd_rdy,
    input logic       wr_rdy,
    input logic       idle_rdy
);

    AST_RDA_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2 && ap) |=> (!rd_rdy && !wr_rdy));                         // R2
    AST_WRA_HOLDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd3 && ap) |=> !rd_rdy);                                      // R4
    AST_PA_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 || cmd == 3'd4) |-> !viol);                               // R6
    AST_BUSY_MODE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd5 || cmd == 3'd6) && !idle_rdy) |-> (viol && viol_code == 3'd5)); // R8
    AST_IDLE_MODE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd5 || cmd == 3'd6) && idle_rdy) |-> !viol);                 // R8
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 && idle_rdy) |=> !idle_rdy);                              // R9
    AST_RDY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rdy && wr_rdy && !((cmd == 3'd2 || cmd == 3'd3) && ap)) |=> (rd_rdy && wr_rdy)); // R10

endmodule

bind ddr2_ap_gap_checker ddr2_ap_gap_props u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .ap        (ap),
    .viol      (viol),
    .viol_code (viol_code),
    .rd_rdy    (rd_rdy),
    .wr_rdy    (wr_rdy),
    .idle_rdy  (idle_rdy)
);

// File: tb/ddr2_ap_gap_checker_bench.sv
module ddr2_ap_gap_checker_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [1:0] bank = 2'd0;
    logic       ap = 1'b0;
    logic [2:0] cfg_cl = 3'd5;
    logic       cfg_bl8 = 1'b1;
    logic [3:0] cfg_wtr = 4'd3;
    logic [3:0] cfg_twr = 4'd4;
    logic [3:0] cfg_trp = 4'd3;
    logic       viol;
    logic [2:0] viol_code;
    logic       rd_rdy, wr_rdy, idle_rdy;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string phase = "R1";

    // reference model state
    int cyc;
    int m_cl, m_blh, m_wtr, m_twr, m_trp;
    bit ap_vld, ap_wr;
    int ap_t, ap_bank;
    bit bopen[4];
    int idle_at[4];

    always #4 clk = ~clk;   // 125 MHz

    ddr2_ap_gap_checker u_ddr2_ap_gap_checker (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .ap(ap),
        .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8), .cfg_wtr(cfg_wtr), .cfg_twr(cfg_twr),
        .cfg_trp(cfg_trp), .viol(viol), .viol_code(viol_code),
        .rd_rdy(rd_rdy), .wr_rdy(wr_rdy), .idle_rdy(idle_rdy)
    );

    function automatic string code_tag(int code);
        case (code)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R8";
            default: return phase;
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s cycle %0d %s actual=%0d expected=%0d", tag, cyc, what, act, exp);
        end
    endtask

    task automatic do_reset(int cl, bit bl8, int wtr, int twr, int trp);
        @(negedge clk);
        rst_n = 1'b0; cmd = 3'd0; bank = 2'd0; ap = 1'b0;
        cfg_cl = 3'(cl); cfg_bl8 = bl8; cfg_wtr = 4'(wtr); cfg_twr = 4'(twr); cfg_trp = 4'(trp);
        repeat (3) @(negedge clk);
        m_cl = cl; m_blh = bl8 ? 4 : 2; m_wtr = (wtr < 2) ? 2 : wtr; m_twr = twr; m_trp = trp;
        ap_vld = 0; ap_wr = 0; ap_t = 0; ap_bank = 0; cyc = 0;
        for (int b = 0; b < 4; b++) begin bopen[b] = 0; idle_at[b] = 0; end
        rst_n = 1'b1;
    endtask

    // One command per cycle: drive after the falling edge, compare before the rising edge.
    task automatic step(int c, int bk, bit a);
        int rd_min, wr_min, e_code, d;
        bit e_idle, e_rd, e_wr;
        @(negedge clk);
        cmd = 3'(c); bank = 2'(bk); ap = a;
        #2;
        rd_min = ap_wr ? (m_cl - 1 + m_blh + m_wtr) : m_blh;
        wr_min = ap_wr ? m_blh : (m_blh + 2);
        d = cyc - ap_t;
        e_rd = !ap_vld || d >= rd_min;
        e_wr = !ap_vld || d >= wr_min;
        e_idle = 1;
        for (int b = 0; b < 4; b++) if (bopen[b] || cyc < idle_at[b]) e_idle = 0;
        e_code = 0;
        if (c == 2 && ap_vld && bk != ap_bank && d < rd_min) e_code = ap_wr ? 3 : 1;
        else if (c == 3 && ap_vld && bk != ap_bank && d < wr_min) e_code = ap_wr ? 4 : 2;
        else if ((c == 5 || c == 6) && !e_idle) e_code = 5;
        check(code_tag(e_code != 0 ? e_code : int'(viol_code)), "viol_code", int'(viol_code), e_code);
        check(code_tag(e_code), "viol", int'(viol), int'(e_code != 0));
        check("R10", "rd_rdy", int'(rd_rdy), int'(e_rd));
        check("R10", "wr_rdy", int'(wr_rdy), int'(e_wr));
        check("R9", "idle_rdy", int'(idle_rdy), int'(e_idle));
        // model update
        if (c == 1 && !bopen[bk] && cyc >= idle_at[bk]) bopen[bk] = 1;
        else if (c == 4 && bopen[bk]) begin bopen[bk] = 0; idle_at[bk] = cyc + m_trp; end
        else if ((c == 2 || c == 3) && a && bopen[bk]) begin
            bopen[bk] = 0;
            idle_at[bk] = cyc + m_trp + ((c == 3) ? (m_cl - 1 + m_blh + m_twr) : m_blh);
        end
        if ((c == 2 || c == 3) && a) begin
            ap_vld = 1; ap_t = cyc; ap_wr = (c == 3); ap_bank = bk;
        end
        cyc++;
    endtask

    task automatic nops(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic sweep(int c, int bk, int n);
        for (int i = 0; i < n; i++) step(c, bk, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Setting A: BL8, CL5, wtr 3, twr 4, trp 3
        do_reset(5, 1, 3, 4, 3);
        phase = "R1";  nops(2);
        // R11: change the settings after reset; model keeps the captured ones
        cfg_cl = 3'd3; cfg_bl8 = 1'b0; cfg_wtr = 4'd9; cfg_twr = 4'd1; cfg_trp = 4'd7;
        phase = "R11"; nops(1);
        phase = "R2";  step(1, 0, 0); step(1, 1, 0); step(2, 0, 1); sweep(2, 1, 6);
        phase = "R6";  step(2, 0, 0); step(1, 2, 0); step(4, 2, 0); step(4, 3, 0); nops(14);
        phase = "R3";  step(1, 0, 0); step(2, 0, 1); sweep(3, 1, 8); nops(12);
        phase = "R4";  step(1, 0, 0); step(3, 0, 1); sweep(2, 1, 13); step(3, 0, 0);
        phase = "R8";  step(5, 0, 0); step(6, 0, 0); nops(20); step(4, 1, 0);
        sweep(5, 0, 4); step(6, 0, 0);
        phase = "R5";  step(1, 0, 0); step(1, 1, 0); step(3, 0, 1); sweep(3, 1, 6);
        phase = "R9";  sweep(5, 2, 24); step(4, 1, 0); sweep(5, 2, 5);
        phase = "R12"; step(1, 0, 0); step(1, 1, 0); step(2, 0, 1); step(3, 1, 1);
        sweep(2, 0, 13); nops(24);

        // Setting B: BL4, CL3, wtr 1 (clamped to 2 for R7), twr 2, trp 2
        do_reset(3, 0, 1, 2, 2);
        phase = "R1";  nops(1);
        phase = "R7";  step(1, 0, 0); step(1, 1, 0); step(3, 0, 1); sweep(2, 1, 8);
        phase = "R3";  nops(10); step(1, 0, 0); step(2, 0, 1); sweep(3, 1, 6);
        phase = "R9";  step(4, 1, 0); sweep(5, 3, 5);
        phase = "R6";  step(1, 2, 0); step(2, 2, 1); step(1, 3, 0); step(4, 3, 0);
        step(2, 2, 0); nops(8);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule